// File: doc/BRIEF.md
# Busy-Handshake Host Interface with Passthrough

This block sits between a host port and a single-wire bus timing engine. The host prepares two command levels, a data/clock level and a reset-request level, and then pulls an active-low enable input low. On that falling edge the block latches the commands and starts one slot on the bus engine. It then uses a single pair of status outputs for three jobs. First it shows a busy code, which differs between reset slots and bit slots. Later it reports the sampled bus result when the host queries it. At all other times it passes through two status lines coming from the next unit downstream.

Several units can be chained ahead of a printer. Each unit hands its enable on to the next one and copies the downstream status lines back toward the host. During every reset slot a unit checks whether a downstream unit answered with the reset-busy code. If no unit answered, it marks itself as the end of the chain. From then on it stops forwarding enable and ignores the downstream lines while a slot is active. All host and downstream inputs are asynchronous and are synchronized inside the block. Waveform timing and mode sequencing belong to other blocks.

Top module: `busy_host_if`

## Requirements
- R1: A falling edge of the synchronized enable, seen while idle, produces a one-cycle `slot_start` pulse. In that same cycle, `slot_is_reset` and `slot_bit_val` take the synchronized reset-request and data/clock levels, and they hold those values until the next start.
- R2: A reset slot drives `st_o1`=0 and `st_o2`=1 for `RST_HI_US*CYC_PER_US` cycles, counted from the `slot_start` cycle. After that, both outputs are 0.
- R3: A bit slot drives both status outputs to 0 from the `slot_start` cycle onward. In any slot, both outputs stay 0 after the busy code until `slot_done` is seen, whatever the downstream inputs do.
- R4: After `slot_done`, while enable stays low and the data/clock level is high, the status outputs follow the downstream inputs (`st_o1`←`ds_i1`, `st_o2`←`ds_i2`). The end-of-chain case in R8 is the exception.
- R5: After `slot_done`, a low data/clock level with a result of 0 forces both outputs to 0. This holds until enable returns high, and downstream changes do not affect it. With a result of 1, the outputs keep following as in R4.
- R6: While the synchronized enable is high, `st_o1`=`ds_i1` and `st_o2`=`ds_i2`.
- R7: In a reset slot, the downstream inputs are sampled `CYC_PER_US` cycles after `slot_start`. If they read `ds_i1`=0 and `ds_i2`=1, the unit is not last. Any other value marks it last. While it is last, `en_out_n` is 1. Otherwise `en_out_n` equals the synchronized enable. After reset the unit is not last.
- R8: While the unit is last and enable is low, the pass-through value is 1 on both outputs, and the downstream inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_in_n | input | 1 | Host enable, active low, asynchronous |
| dclk_in | input | 1 | Host data/clock level, asynchronous |
| rreq_in | input | 1 | Host reset-request level, asynchronous |
| ds_i1 | input | 1 | Downstream status line 1, asynchronous |
| ds_i2 | input | 1 | Downstream status line 2, asynchronous |
| slot_done | input | 1 | Bus engine: slot finished (one-cycle pulse) |
| slot_result | input | 1 | Bus engine: sampled bus level, valid with slot_done |
| slot_start | output | 1 | Start pulse to the bus engine |
| slot_is_reset | output | 1 | Latched slot type, 1 = reset slot |
| slot_bit_val | output | 1 | Latched data/clock level for a bit slot |
| st_o1 | output | 1 | Status output 1 toward the host |
| st_o2 | output | 1 | Status output 2 toward the host |
| en_out_n | output | 1 | Enable toward the next unit, active low |

## Verification
The hardest condition to reach is an end-of-chain unit that must lose that status again. The downstream lines are sampled only once, at a single cycle inside a reset slot. So the bench holds the presence code on the downstream inputs for the whole window of one reset slot and a non-presence level for another. It then runs a further reset slot with the presence code and checks that the enable output follows the host again. The end-of-chain masking is also exercised: the downstream lines are driven to all zeros after completion, and the outputs must stay high.

// File: rtl/busy_host_if_pkg.sv
package busy_host_if_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_RSTHI = 3'd1,
      PH_BUSY  = 3'd2,
      PH_DONE  = 3'd3,
      PH_FORCE = 3'd4
   } phase_t;
endpackage

// File: rtl/busy_host_if_sync.sv
module busy_host_if_sync #(
   parameter int          WIDTH   = 1,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("busy_host_if_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= RST_VAL;
      else        chain_q[0] <= d_in;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= RST_VAL;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   endgenerate

   assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/busy_host_if_phase.sv
module busy_host_if_phase
   import busy_host_if_pkg::*;
#(
   parameter int HI_CYC  = 8,
   parameter int SMP_CYC = 4
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   en_s,
   input  logic   dclk_s,
   input  logic   rreq_s,
   input  logic   slot_done,
   input  logic   slot_result,
   output phase_t phase,
   output logic   start_q,
   output logic   is_reset_q,
   output logic   bit_val_q,
   output logic   smp_strobe
);
   localparam int CW = $clog2(HI_CYC + 1);

   generate
      if (HI_CYC < 2 || SMP_CYC < 1 || SMP_CYC >= HI_CYC) begin : g_bad
         $error("busy_host_if_phase: need 1 <= SMP_CYC < HI_CYC, HI_CYC >= 2");
      end
   endgenerate

   phase_t         ph_q;
   logic [CW-1:0]  cnt_q;
   logic           en_d_q;
   logic           res_q;
   logic           en_fall;

   assign en_fall    = en_d_q & ~en_s;
   assign phase      = ph_q;
   assign smp_strobe = (ph_q == PH_RSTHI) && (cnt_q == CW'(SMP_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         cnt_q      <= '0;
         en_d_q     <= 1'b1;
         res_q      <= 1'b1;
         start_q    <= 1'b0;
         is_reset_q <= 1'b0;
         bit_val_q  <= 1'b1;
      end else begin
         en_d_q  <= en_s;
         start_q <= 1'b0;
         case (ph_q)
            PH_IDLE: begin
               if (en_fall) begin
                  start_q    <= 1'b1;
                  is_reset_q <= rreq_s;
                  bit_val_q  <= dclk_s;
                  cnt_q      <= '0;
                  ph_q       <= rreq_s ? PH_RSTHI : PH_BUSY;
               end
            end
            PH_RSTHI: begin
               cnt_q <= cnt_q + 1'b1;
               if (slot_done) begin
                  res_q <= slot_result;
                  ph_q  <= PH_DONE;
               end else if (cnt_q == CW'(HI_CYC - 1)) begin
                  ph_q <= PH_BUSY;
               end
            end
            PH_BUSY: begin
               if (slot_done) begin
                  res_q <= slot_result;
                  ph_q  <= PH_DONE;
               end
            end
            PH_DONE: begin
               if (en_s)                  ph_q <= PH_IDLE;
               else if (!dclk_s && !res_q) ph_q <= PH_FORCE;
            end
            PH_FORCE: begin
               if (en_s) ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(ph_q) == PH_IDLE);                                   // R1
   AST_HI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RSTHI) |-> cnt_q < CW'(HI_CYC));                            // R2
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_BUSY && !slot_done) |=> ph_q == PH_BUSY);                  // R3
   AST_FORCE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_FORCE && !en_s) |=> ph_q == PH_FORCE);                     // R5
endmodule

// File: rtl/busy_host_if_chain.sv
module busy_host_if_chain (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_strobe,
   input  logic ds1_s,
   input  logic ds2_s,
   output logic last_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          last_q <= 1'b0;
      else if (smp_strobe) last_q <= !(!ds1_s && ds2_s);
   end

   AST_LAST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_strobe |=> $stable(last_q));                                      // R7
endmodule

// File: rtl/busy_host_if.sv
module busy_host_if
   import busy_host_if_pkg::*;
#(
   parameter int CYC_PER_US  = 4,
   parameter int RST_HI_US   = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_in_n,
   input  logic dclk_in,
   input  logic rreq_in,
   input  logic ds_i1,
   input  logic ds_i2,
   input  logic slot_done,
   input  logic slot_result,
   output logic slot_start,
   output logic slot_is_reset,
   output logic slot_bit_val,
   output logic st_o1,
   output logic st_o2,
   output logic en_out_n
);
   localparam int HI_CYC  = RST_HI_US * CYC_PER_US;
   localparam int SMP_CYC = CYC_PER_US;

   generate
      if (CYC_PER_US < 1 || RST_HI_US < 2) begin : g_bad
         $error("busy_host_if: CYC_PER_US >= 1 and RST_HI_US >= 2 required");
      end
   endgenerate

   logic [4:0] raw_in, syn;
   logic       en_s, dclk_s, rreq_s, ds1_s, ds2_s;
   phase_t     phase;
   logic       smp_strobe, last_q;
   logic [1:0] pass_v, st_v;

   assign raw_in = {en_in_n, dclk_in, rreq_in, ds_i1, ds_i2};

   busy_host_if_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11011)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_in(raw_in), .d_out(syn));

   assign {en_s, dclk_s, rreq_s, ds1_s, ds2_s} = syn;

   busy_host_if_phase #(.HI_CYC(HI_CYC), .SMP_CYC(SMP_CYC)) u_phase (
      .clk(clk), .rst_n(rst_n), .en_s(en_s), .dclk_s(dclk_s), .rreq_s(rreq_s),
      .slot_done(slot_done), .slot_result(slot_result), .phase(phase),
      .start_q(slot_start), .is_reset_q(slot_is_reset), .bit_val_q(slot_bit_val),
      .smp_strobe(smp_strobe));

   busy_host_if_chain u_chain (
      .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe),
      .ds1_s(ds1_s), .ds2_s(ds2_s), .last_q(last_q));

   assign pass_v = (last_q && !en_s) ? 2'b11 : {ds1_s, ds2_s};

   always_comb begin
      if (en_s) begin
         st_v = {ds1_s, ds2_s};
      end else begin
         case (phase)
            PH_RSTHI: st_v = 2'b01;
            PH_BUSY:  st_v = 2'b00;
            PH_FORCE: st_v = 2'b00;
            default:  st_v = pass_v;
         endcase
      end
   end

   assign {st_o1, st_o2} = st_v;
   assign en_out_n       = last_q | en_s;

   AST_EN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      en_s |-> (st_o1 == ds1_s && st_o2 == ds2_s));                          // R6
endmodule

// File: tb/busy_host_if_tb_top.sv
module busy_host_if_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CPU = 4;
   localparam int HI  = 2 * CPU;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_in_n = 1'b1, dclk_in = 1'b1, rreq_in = 1'b0;
   logic ds_i1 = 1'b1, ds_i2 = 1'b1;
   logic slot_done = 1'b0, slot_result = 1'b0;
   logic slot_start, slot_is_reset, slot_bit_val, st_o1, st_o2, en_out_n;

   always #(CLK_PERIOD/2) clk = ~clk;

   busy_host_if #(.CYC_PER_US(CPU), .RST_HI_US(2), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_in_n(en_in_n), .dclk_in(dclk_in),
      .rreq_in(rreq_in), .ds_i1(ds_i1), .ds_i2(ds_i2), .slot_done(slot_done),
      .slot_result(slot_result), .slot_start(slot_start),
      .slot_is_reset(slot_is_reset), .slot_bit_val(slot_bit_val),
      .st_o1(st_o1), .st_o2(st_o2), .en_out_n(en_out_n));

   typedef struct {
      bit         kind;   // 0: {st_o1,st_o2,en_out_n}  1: {0,slot_is_reset,slot_bit_val}
      logic [2:0] exp;
      string      tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_chk = 0, n_bad = 0;
   bit done_f = 1'b0;

   // monitor: pops expected items and compares with the design outputs
   initial begin
      forever begin
         wait (sb_q.size() != 0);
         begin
            automatic sb_item_t it = sb_q.pop_front();
            automatic logic [2:0] act = it.kind ? {1'b0, slot_is_reset, slot_bit_val}
                                                : {st_o1, st_o2, en_out_n};
            n_chk++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s actual=%b expected=%b", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic expect_st(input logic [2:0] e, input string tag);
      sb_item_t it;
      it.kind = 1'b0; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      #1;
   endtask

   task automatic expect_cmd(input logic [1:0] e, input string tag);
      sb_item_t it;
      it.kind = 1'b1; it.exp = {1'b0, e}; it.tag = tag;
      sb_q.push_back(it);
      #1;
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic start_slot(input logic rq, input logic dc, input string tag);
      bit seen = 1'b0;
      rreq_in = rq; dclk_in = dc;
      cyc(1);
      en_in_n = 1'b0;
      for (int i = 0; i < 8 && !seen; i++) begin
         cyc(1);
         if (slot_start) seen = 1'b1;
      end
      n_chk++;
      if (!seen) begin
         n_bad++;
         $display("FAIL %s slot_start actual=0 expected=1", tag);
      end
   endtask

   task automatic finish_slot(input logic res);
      slot_result = res; slot_done = 1'b1;
      cyc(1);
      slot_done = 1'b0;
   endtask

   task automatic report;
      if (!done_f) begin
         done_f = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      report();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(3);
      expect_st(3'b111, "R6 reset state");
      ds_i1 = 0; ds_i2 = 1; cyc(3);
      expect_st(3'b011, "R6 pass 01");
      ds_i1 = 1; ds_i2 = 0; cyc(3);
      expect_st(3'b101, "R6 pass 10");

      // A: reset slot, downstream present
      ds_i1 = 0; ds_i2 = 1;
      start_slot(1'b1, 1'b1, "R1 reset slot start");
      expect_st(3'b010, "R2 reset busy code at start");
      expect_cmd(2'b11, "R1 captured reset command");
      cyc(HI - 1);
      expect_st(3'b010, "R2 reset busy code last cycle");
      cyc(1);
      expect_st(3'b000, "R2 both low after window");
      ds_i1 = 1; ds_i2 = 1; cyc(3);
      expect_st(3'b000, "R3 busy ignores downstream");
      finish_slot(1'b1); cyc(3);
      expect_st(3'b110, "R4 follow after done");
      ds_i2 = 0; cyc(3);
      expect_st(3'b100, "R4 follow change");
      dclk_in = 0; cyc(4);
      expect_st(3'b100, "R5 high result keeps follow");
      en_in_n = 1; cyc(4);
      expect_st(3'b101, "R6 enable high passthrough");
      dclk_in = 1;

      // B: bit slot, result 0
      ds_i1 = 1; ds_i2 = 1;
      start_slot(1'b0, 1'b1, "R1 bit slot start");
      expect_st(3'b000, "R3 bit busy immediate");
      expect_cmd(2'b01, "R1 captured bit command");
      finish_slot(1'b0); cyc(3);
      expect_st(3'b110, "R4 follow before query");
      dclk_in = 0; cyc(4);
      expect_st(3'b000, "R5 low result forced");
      ds_i2 = 0; cyc(3);
      expect_st(3'b000, "R5 forced ignores downstream");
      en_in_n = 1; cyc(4);
      expect_st(3'b101, "R6 release after forced");
      dclk_in = 1;

      // C: reset slot, no downstream -> last
      ds_i1 = 1; ds_i2 = 1;
      start_slot(1'b1, 1'b1, "R7 reset slot alone");
      cyc(HI);
      expect_st(3'b001, "R7 last holds en_out high");
      finish_slot(1'b1); cyc(3);
      expect_st(3'b111, "R8 last pass value");
      ds_i1 = 0; ds_i2 = 0; cyc(3);
      expect_st(3'b111, "R8 last ignores downstream");
      en_in_n = 1; cyc(4);
      expect_st(3'b001, "R6 last with enable high");

      // D: reset slot with presence clears last
      ds_i1 = 0; ds_i2 = 1;
      start_slot(1'b1, 1'b1, "R7 reset slot presence");
      cyc(HI);
      expect_st(3'b000, "R7 not last en_out follows");
      finish_slot(1'b1); cyc(1);
      en_in_n = 1; cyc(4);

      // E: write-0 style slot, data/clock already low
      ds_i1 = 1; ds_i2 = 1;
      start_slot(1'b0, 1'b0, "R1 write0 start");
      expect_cmd(2'b00, "R1 captured write0 command");
      finish_slot(1'b0); cyc(3);
      expect_st(3'b000, "R5 immediate force with low dclk");
      en_in_n = 1; cyc(4);
      expect_st(3'b111, "R6 idle after write0");

      wait (sb_q.size() == 0);
      #1;
      report();
   end
endmodule